// File: doc/BRIEF.md
# Imprecise Abort Hold Unit

This unit keeps track of asynchronous (imprecise) data aborts while a core moves into and out of a halted debug state. An abort report that arrives during normal running, or during the halted period before the first barrier after entry has drained, is held together with its type code. That abort is later requested from the core once the core is running and the abort mask bit is clear.

Once a barrier has completed during the halted period, a drained flag is raised. From then on, further abort reports only produce a sticky pulse for the status logic and are otherwise dropped. They never replace an abort that is already held. Leaving the halted state clears the drained flag. The core accepts a pending abort with a one-cycle acknowledge, and that acknowledge empties the hold register.

Top module: `imp_abort_hold`

## Requirements
- R1: After reset, `drained` is 0, `sticky_set` is 0, `take_req` is 0 and `held_type` is 0.
- R2: While `halted` is 1, a `barrier_done` pulse sets `drained` one clock later. `drained` then stays set while `halted` remains 1. A `barrier_done` while `halted` is 0 leaves `drained` at 0.
- R3: `drained` reads 0 one clock after `halted` is sampled 0, so it is 0 on every entry to the halted state.
- R4: An abort report while halted with `drained` at 0 is held with its type, which appears on `held_type` one clock later. The same report pulses `sticky_set` for exactly one clock, one clock after the report.
- R5: An abort report while halted with `drained` at 1 pulses `sticky_set` one clock later. Its type is discarded, and `held_type` keeps the previously held value.
- R6: `take_req` is 1 exactly when an abort is held, `mask` is 0 and `halted` is 0. This is a combinational function of the current inputs and the held state. It is never 1 while halted.
- R7: On leaving the halted state, a held abort is requested at once if `mask` is 0. If `mask` is 1, the abort stays held without a request until `mask` falls.
- R8: An abort report outside the halted state while `mask` is 1 is held, with no request, until `mask` becomes 0.
- R9: A clock edge with `take_req` and `take_ack` both 1 empties the hold register. After that edge, `take_req` is 0 and `held_type` is 0.
- R10: An abort report in the same cycle as a `barrier_done` while halted, with `drained` at 0, is held with its type. `drained` is still set one clock later.
- R11: While an abort is held outside the halted state, a further report does not replace the held type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| abt_valid | input | 1 | Imprecise abort report |
| abt_type | input | TYPE_W | Type code of the reported abort |
| halted | input | 1 | Core is in the halted debug state |
| mask | input | 1 | Abort mask bit of the core |
| barrier_done | input | 1 | Memory barrier completion pulse |
| take_ack | input | 1 | Core accepts the abort request |
| drained | output | 1 | Barrier-drained flag (status bit 19) |
| sticky_set | output | 1 | Pulse that sets the sticky imprecise-abort bit |
| held_type | output | TYPE_W | Type of the held abort, 0 when none is held |
| take_req | output | 1 | Request that the core take the held abort |

## Verification
Abort reports are applied in four positions: before the drain in the halted state, after the drain in the halted state, in the same cycle as the barrier, and during normal running with the mask set. Together these positions separate the latch path from the discard path, and show whether the same-cycle case is resolved toward latching. Exits from the halted state are tried with the mask both clear and set. These exits tell an immediate request apart from a deferred one. A second report while an abort is held, and a barrier outside the halted state, check that neither changes held state.

// File: rtl/imp_abort_hold.sv
module imp_abort_hold #(
  parameter int TYPE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abt_valid,
  input  logic [TYPE_W-1:0] abt_type,
  input  logic              halted,
  input  logic              mask,
  input  logic              barrier_done,
  input  logic              take_ack,
  output logic              drained,
  output logic              sticky_set,
  output logic [TYPE_W-1:0] held_type,
  output logic              take_req
);

  logic              pend_q;
  logic [TYPE_W-1:0] type_q;
  logic              drained_q;
  logic              sticky_q;
  logic              taken;
  logic              pend_keep;
  logic              capture;

  assign take_req  = pend_q & ~mask & ~halted;
  assign taken     = take_req & take_ack;
  assign pend_keep = pend_q & ~taken;
  assign capture   = abt_valid & ~pend_keep & ~(halted & drained_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      type_q    <= '0;
      drained_q <= 1'b0;
      sticky_q  <= 1'b0;
    end else begin
      drained_q <= halted & (drained_q | barrier_done);
      sticky_q  <= halted & abt_valid;
      if (capture) begin
        pend_q <= 1'b1;
        type_q <= abt_type;
      end else if (taken) begin
        pend_q <= 1'b0;
        type_q <= '0;
      end
    end
  end

  assign drained    = drained_q;
  assign sticky_set = sticky_q;
  assign held_type  = type_q;

  a_r2_drain_set: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && barrier_done) |=> drained);
  a_r3_drain_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> !drained);
  a_r4_sticky_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && abt_valid) |=> sticky_set);
  a_r5_type_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && drained) |=> $stable(held_type));
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && mask) |=> pend_q);
  a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && take_ack && !abt_valid) |=> !pend_q);

endmodule

// File: tb/imp_abort_hold_tb_top.sv
module imp_abort_hold_tb_top;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abt_valid = 1'b0;
  logic [TW-1:0] abt_type = '0;
  logic halted = 1'b0;
  logic mask = 1'b0;
  logic barrier_done = 1'b0;
  logic take_ack = 1'b0;
  logic drained, sticky_set, take_req;
  logic [TW-1:0] held_type;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  imp_abort_hold #(.TYPE_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .abt_valid(abt_valid), .abt_type(abt_type),
    .halted(halted), .mask(mask), .barrier_done(barrier_done),
    .take_ack(take_ack), .drained(drained), .sticky_set(sticky_set),
    .held_type(held_type), .take_req(take_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic report(input logic [TW-1:0] t);
    abt_valid = 1'b1; abt_type = t;
    nxt();
    abt_valid = 1'b0; abt_type = '0;
  endtask

  task automatic accept();
    take_ack = 1'b1;
    nxt();
    take_ack = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 drained", drained, 0);
    chk("R1 sticky", sticky_set, 0);
    chk("R1 take_req", take_req, 0);
    chk("R1 type", held_type, 0);
  endtask

  task automatic t_halt_unmasked();
    halted = 1'b1; mask = 1'b0;
    nxt();
    report(4'h5);
    chk("R4 sticky", sticky_set, 1);
    chk("R4 type", held_type, 4'h5);
    chk("R6 no req halted", take_req, 0);
    nxt();
    chk("R4 pulse width", sticky_set, 0);
    barrier_done = 1'b1; nxt(); barrier_done = 1'b0;
    chk("R2 drained set", drained, 1);
    nxt();
    chk("R2 drained hold", drained, 1);
    report(4'h9);
    chk("R5 sticky", sticky_set, 1);
    chk("R5 type kept", held_type, 4'h5);
    halted = 1'b0; #1;
    chk("R7 req on exit", take_req, 1);
    nxt();
    chk("R3 drained clear", drained, 0);
    chk("R6 req held", take_req, 1);
    accept();
    chk("R9 req cleared", take_req, 0);
    chk("R9 type cleared", held_type, 0);
  endtask

  task automatic t_halt_masked();
    halted = 1'b1; mask = 1'b1;
    nxt();
    report(4'h3);
    barrier_done = 1'b1; nxt(); barrier_done = 1'b0;
    halted = 1'b0;
    nxt(); nxt();
    chk("R7 masked no req", take_req, 0);
    chk("R7 masked type", held_type, 4'h3);
    mask = 1'b0; #1;
    chk("R7 req after unmask", take_req, 1);
    accept();
    chk("R9 cleared", take_req, 0);
  endtask

  task automatic t_same_cycle();
    halted = 1'b1; mask = 1'b0;
    nxt();
    abt_valid = 1'b1; abt_type = 4'h7; barrier_done = 1'b1;
    nxt();
    abt_valid = 1'b0; abt_type = '0; barrier_done = 1'b0;
    chk("R10 type", held_type, 4'h7);
    chk("R10 drained", drained, 1);
    halted = 1'b0; #1;
    chk("R10 req on exit", take_req, 1);
    accept();
    chk("R9 cleared", held_type, 0);
  endtask

  task automatic t_running_masked();
    halted = 1'b0; mask = 1'b1;
    nxt();
    report(4'h2);
    chk("R8 no req", take_req, 0);
    chk("R8 type", held_type, 4'h2);
    report(4'hC);
    chk("R11 type kept", held_type, 4'h2);
    mask = 1'b0; #1;
    chk("R8 req after unmask", take_req, 1);
    accept();
    chk("R9 cleared", take_req, 0);
  endtask

  task automatic t_idle_barrier();
    halted = 1'b0;
    barrier_done = 1'b1; nxt(); barrier_done = 1'b0;
    chk("R2 no drain idle", drained, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    nxt(); nxt();
    t_reset();
    rst_n = 1'b1;
    nxt();
    t_reset();
    t_idle_barrier();
    t_halt_unmasked();
    t_halt_masked();
    t_same_cycle();
    t_running_masked();
    nxt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule